// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block connects an on-chip requester to an external, clockless static RAM holding 524,288 bytes (19-bit byte address, 8-bit data). The requester offers one access at a time with a valid/ready handshake, a direction flag, an address and, for stores, one byte. The block converts each accepted access into a sequence of the three active-low memory strobes (select, output enable, write enable), together with a held address and a data bus split into output value, output enable and input value. The pad ring merges these three into the bidirectional pins. Load data returns as a byte with a one-clock valid strobe.

All memory timing is expressed as wait-state counts. The block derives them at elaboration from the clock period and the memory's access time, minimum write pulse, data setup and write cycle time, so the same RTL serves any clock rate. Every access is bracketed by idle cycles with all strobes inactive. As a result the address never moves while the memory is selected. A load that follows a store finds the data bus already released for a full cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, select, output enable and write enable are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high exactly when the sequencer is idle. An access is taken on a clock edge where `req_valid` and `req_ready` are both high. During every idle cycle all three strobes are high and `mem_dq_oe` is low.
- R3: A load holds select and output enable low and write enable high for exactly RD = max(1, ceil(T_ACCESS/T_CLK)) consecutive cycles. These start in the cycle after acceptance. At 4 ns and 12 ns, RD = 3. The strobes rise together after the last of those cycles.
- R4: In the cycle after a load's strobes rise, `rsp_valid` is high for exactly one cycle. `rsp_data` then equals the byte present on `mem_dq_in` during the last strobed cycle, which is the byte most recently stored at that address.
- R5: A store runs as follows. First comes one setup cycle with select low and write and output enable high. Then write enable is low with select low for WP consecutive cycles. Then comes one recovery cycle with all strobes high. WP is the largest of 1, ceil(T_WPULSE/T_CLK), ceil(T_DSETUP/T_CLK)-1 and ceil(T_WCYCLE/T_CLK)-2, which is 2 at 4 ns, 8 ns, 6 ns and 12 ns.
- R6: Output enable stays high throughout a store. `mem_dq_oe` is high exactly in the setup and write-enable cycles, and in those cycles `mem_dq_out` carries the accepted store byte.
- R7: `mem_addr` equals the accepted address for the whole access. It does not change in any cycle where select was low in the previous cycle and is still low.
- R8: Output enable is never low while `mem_dq_oe` is high. At least one full cycle with the bus released separates the last driven cycle from any cycle with output enable low.
- R9: Each write-enable pulse lasts at least T_WPULSE. The stored byte is stable and driven for at least T_DSETUP before write enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Access can be taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Store byte |
| rsp_valid | output | 1 | One-cycle strobe: load byte available |
| rsp_data | output | 8 | Load byte |
| mem_addr | output | 19 | Address bus to the memory |
| mem_sel_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data value toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Data value seen on the pins |

## Verification
The most delicate situations are the edges of the timing windows. One is a load sampled before the access time has elapsed. The other is a store whose data is not yet stable when write enable rises. Neither is visible from the handshake alone. The bench's memory model therefore returns a poison byte until the strobes have been low for the full access time. It also measures each write pulse and data-stable window in clock periods before it commits the byte. A sweep first stores all 256 byte values, every one-hot address and both address extremes. It then reads each location back with the load issued in the cycle right after the previous access, so every read-after-write turnaround gap is exercised at its minimum.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_WAIT    = 3'd1,
        ST_WR_SETUP   = 3'd2,
        ST_WR_PULSE   = 3'd3,
        ST_WR_RECOVER = 3'd4
    } seq_state_e;

    // Active-low strobes plus data drive enable, as one registered bundle
    typedef struct packed {
        logic sel_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_QUIET    = '{sel_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    localparam bus_ctl_t CTL_LOAD     = '{sel_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
    localparam bus_ctl_t CTL_ST_SETUP = '{sel_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
    localparam bus_ctl_t CTL_ST_PULSE = '{sel_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0);  // R3

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYCLES = 3,
    parameter int WP_CYCLES = 2,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             timer_done,
    output logic             req_ready,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture_rd,
    output bus_ctl_t         bus_ctl,
    output logic             rd_valid
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYCLES - 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYCLES - 1);

    typedef struct packed {
        seq_state_e state;
        bus_ctl_t   ctl;
        logic       rd_valid;
    } fsm_regs_t;

    localparam fsm_regs_t FSM_RESET = '{state: ST_IDLE, ctl: CTL_QUIET, rd_valid: 1'b0};

    fsm_regs_t d, q;

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        accept     = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        capture_rd = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        d.state = ST_WR_SETUP;
                        d.ctl   = CTL_ST_SETUP;
                    end else begin
                        d.state  = ST_RD_WAIT;
                        d.ctl    = CTL_LOAD;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            ST_RD_WAIT: begin
                if (timer_done) begin
                    capture_rd = 1'b1;
                    d.rd_valid = 1'b1;
                    d.state    = ST_IDLE;
                    d.ctl      = CTL_QUIET;
                end
            end
            ST_WR_SETUP: begin
                d.state  = ST_WR_PULSE;
                d.ctl    = CTL_ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WP_LOAD;
            end
            ST_WR_PULSE: begin
                if (timer_done) begin
                    d.state = ST_WR_RECOVER;
                    d.ctl   = CTL_QUIET;
                end
            end
            ST_WR_RECOVER: begin
                d.state = ST_IDLE;
                d.ctl   = CTL_QUIET;
            end
            default: begin
                d = FSM_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= FSM_RESET;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == ST_IDLE);
    assign bus_ctl   = q.ctl;
    assign rd_valid  = q.rd_valid;

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_ctl == CTL_QUIET));  // R2
    AST_ACCEPT_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);  // R2
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);  // R4

endmodule

// File: rtl/sram_bus_path.sv
`timescale 1ns/1ps
module sram_bus_path #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture_rd,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } path_regs_t;

    path_regs_t d, q;

    always_comb begin
        d = q;
        if (accept) begin
            d.addr  = req_addr;
            d.wdata = req_wdata;
        end
        if (capture_rd) begin
            d.rdata = dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign addr  = q.addr;
    assign wdata = q.wdata;
    assign rdata = q.rdata;

    AST_PATH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(accept) |-> ($stable(addr) && $stable(wdata)));  // R7

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW           = 19,
    parameter int DW           = 8,
    parameter int T_CLK_PS     = 4000,
    parameter int T_ACCESS_PS  = 12000,
    parameter int T_WPULSE_PS  = 8000,
    parameter int T_DSETUP_PS  = 6000,
    parameter int T_WCYCLE_PS  = 12000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);

    localparam int RD_CYCLES = max2(1, ceil_div(T_ACCESS_PS, T_CLK_PS));
    localparam int WP_CYCLES = max2(max2(1, ceil_div(T_WPULSE_PS, T_CLK_PS)),
                                    max2(ceil_div(T_DSETUP_PS, T_CLK_PS) - 1,
                                         ceil_div(T_WCYCLE_PS, T_CLK_PS) - 2));
    localparam int MAX_WAIT  = max2(RD_CYCLES, WP_CYCLES);
    localparam int CNT_W     = max2(1, $clog2(MAX_WAIT + 1));

    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             capture_rd;
    bus_ctl_t         bus_ctl;

    sram_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_seq_fsm #(
        .RD_CYCLES (RD_CYCLES),
        .WP_CYCLES (WP_CYCLES),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .timer_done (tmr_expired),
        .req_ready  (req_ready),
        .accept     (accept),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .capture_rd (capture_rd),
        .bus_ctl    (bus_ctl),
        .rd_valid   (rsp_valid)
    );

    sram_bus_path #(
        .AW (AW),
        .DW (DW)
    ) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .capture_rd (capture_rd),
        .dq_in      (mem_dq_in),
        .addr       (mem_addr),
        .wdata      (mem_dq_out),
        .rdata      (rsp_data)
    );

    assign mem_sel_n = bus_ctl.sel_n;
    assign mem_oe_n  = bus_ctl.oe_n;
    assign mem_we_n  = bus_ctl.we_n;
    assign mem_dq_oe = bus_ctl.dq_oe;

    AST_ADDR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));  // R7
    AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_sel_n);  // R5
    AST_STORE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe));  // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);  // R8
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));  // R8
    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(mem_dq_oe)) |-> $stable(mem_dq_out));  // R9
    AST_RSP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n));  // R4

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;

    localparam int CLK_PS   = 4000;
    localparam int ACC_PS   = 12000;
    localparam int WPUL_PS  = 8000;
    localparam int DSET_PS  = 6000;
    localparam int WCYC_PS  = 12000;
    localparam int WATCHDOG = 150000;

    function automatic int cdiv(input int n, input int dd);
        return (n + dd - 1) / dd;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_RD = imax(1, cdiv(ACC_PS, CLK_PS));
    localparam int EXP_WP = imax(imax(1, cdiv(WPUL_PS, CLK_PS)),
                                 imax(cdiv(DSET_PS, CLK_PS) - 1, cdiv(WCYC_PS, CLK_PS) - 2));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [18:0] mem_addr;
    logic        mem_sel_n, mem_oe_n, mem_we_n;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  dq_model = 8'hEE;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (dq_model)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ctl();
        return {mem_sel_n, mem_oe_n, mem_we_n, mem_dq_oe};
    endfunction

    // ---------------- behavioural memory model (sampled mid-cycle) ----------
    logic [7:0]  mem [logic [18:0]];
    bit          prev_wr = 0, prev_rd = 0, prev_dqoe = 0;
    logic [18:0] prev_addr = '0, wr_addr = '0;
    logic [7:0]  prev_dq = '0, wr_byte = '0;
    int          wlen = 0, dstable = 0, ds_at_end = 0, gap = 8, rd_age = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_wr = 0; prev_rd = 0; prev_dqoe = 0; wlen = 0;
            dstable = 0; gap = 8; rd_age = 0;
            dq_model <= 8'hEE;
        end else begin
            bit wr_on, rd_on;
            wr_on = !mem_sel_n && !mem_we_n;
            rd_on = !mem_sel_n && !mem_oe_n && mem_we_n;
            if (mem_dq_oe && prev_dqoe && mem_dq_out == prev_dq) dstable++;
            else if (mem_dq_oe) dstable = 1;
            else dstable = 0;
            if (mem_dq_oe) gap = 0;
            else if (gap < 8) gap++;
            if (wr_on) begin
                if (prev_wr) chk(mem_addr == prev_addr, "R7", "addr moved in write", mem_addr, prev_addr);
                chk(mem_dq_oe, "R6", "bus not driven in write", mem_dq_oe, 1);
                wlen++;
                ds_at_end = dstable;
                wr_addr = mem_addr;
                wr_byte = mem_dq_out;
            end else if (prev_wr) begin
                chk(wlen * CLK_PS >= WPUL_PS, "R9", "write pulse ps", wlen * CLK_PS, WPUL_PS);
                chk(ds_at_end * CLK_PS >= DSET_PS, "R9", "data setup ps", ds_at_end * CLK_PS, DSET_PS);
                mem[wr_addr] = wr_byte;
                wlen = 0;
            end
            if (rd_on) begin
                chk(gap >= 2, "R8", "turnaround gap", gap, 2);
                if (prev_rd && mem_addr == prev_addr) rd_age++;
                else rd_age = 1;
            end else begin
                rd_age = 0;
            end
            if (rd_on && rd_age * CLK_PS >= ACC_PS && mem.exists(mem_addr))
                dq_model <= mem[mem_addr];
            else
                dq_model <= 8'hEE;
            prev_wr = wr_on; prev_rd = rd_on; prev_dqoe = mem_dq_oe;
            prev_addr = mem_addr; prev_dq = mem_dq_out;
        end
    end

    // ---------------- access tasks (start and end at a falling edge) --------
    task automatic do_write(input logic [18:0] a, input logic [7:0] dv);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = dv;
        chk(req_ready, "R2", "ready before store", req_ready, 1);
        @(negedge clk);
        req_valid = 0; req_write = 0; req_addr = ~a; req_wdata = ~dv;
        chk(ctl() == 4'b0111, "R5", "setup strobes", ctl(), 4'b0111);
        chk(mem_addr == a, "R7", "store addr", mem_addr, a);
        chk(mem_dq_out == dv, "R6", "store byte", mem_dq_out, dv);
        for (int i = 0; i < EXP_WP; i++) begin
            @(negedge clk);
            chk(ctl() == 4'b0101, "R5", "pulse strobes", ctl(), 4'b0101);
            chk(mem_addr == a, "R7", "addr in pulse", mem_addr, a);
            chk(!req_ready, "R2", "ready while busy", req_ready, 0);
        end
        @(negedge clk);
        chk(ctl() == 4'b1110, "R5", "recovery strobes", ctl(), 4'b1110);
        @(negedge clk);
        chk(req_ready && ctl() == 4'b1110, "R2", "idle after store", {req_ready, ctl()}, 5'b11110);
    endtask

    task automatic do_read(input logic [18:0] a, input logic [7:0] expv);
        req_valid = 1; req_write = 0; req_addr = a;
        chk(req_ready, "R2", "ready before load", req_ready, 1);
        @(negedge clk);
        req_valid = 0; req_addr = ~a;
        for (int i = 0; i < EXP_RD; i++) begin
            chk(ctl() == 4'b0010, "R3", "load strobes", ctl(), 4'b0010);
            chk(mem_addr == a, "R7", "load addr", mem_addr, a);
            chk(!rsp_valid, "R4", "early rsp_valid", rsp_valid, 0);
            @(negedge clk);
        end
        chk(ctl() == 4'b1110, "R3", "strobes released", ctl(), 4'b1110);
        chk(rsp_valid, "R4", "rsp_valid pulse", rsp_valid, 1);
        chk(rsp_data == expv, "R4", "load byte", rsp_data, expv);
        @(negedge clk);
        chk(!rsp_valid, "R4", "rsp_valid width", rsp_valid, 0);
        chk(req_ready, "R2", "idle after load", req_ready, 1);
    endtask

    function automatic logic [18:0] sweep_addr(input int i);
        return 19'((i * 2053 + 7) % 524288);
    endfunction

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL R2 watchdog: actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ctl() == 4'b1110 && req_ready && !rsp_valid, "R1", "in reset",
            {ctl(), req_ready, rsp_valid}, 6'b111010);
        rst_n = 1;
        @(negedge clk);
        chk(ctl() == 4'b1110 && req_ready && !rsp_valid, "R1", "after reset",
            {ctl(), req_ready, rsp_valid}, 6'b111010);

        // every byte value at a spread of addresses
        for (int i = 0; i < 256; i++) do_write(sweep_addr(i), 8'(i));
        // one-hot addresses and extremes (R7 address path)
        for (int k = 0; k < 19; k++) do_write(19'(1) << k, 8'(8'hC0 + k));
        do_write(19'h00000, 8'h5A);
        do_write(19'h7FFFF, 8'hA5);

        // read-after-write with minimum gap, then plain reads
        do_read(19'h7FFFF, 8'hA5);
        do_read(19'h00000, 8'h5A);
        for (int k = 0; k < 19; k++) do_read(19'(1) << k, 8'(8'hC0 + k));
        for (int i = 0; i < 256; i++) do_read(sweep_addr(i), 8'(i));

        // overwrite and alternate store/load on the same location
        for (int j = 0; j < 16; j++) begin
            do_write(19'h12345, 8'(j * 17));
            do_read(19'h12345, 8'(j * 17));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule